// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This block keeps the lane enable mask for one warp, a group of lanes that all run one instruction stream in lockstep while each lane holds its own registers. When the stream reaches a data-dependent branch, the front end sends a command together with a per-lane predicate vector. The unit runs both sides of the branch one after the other. The taken side runs with only the lanes whose predicate is set. The other side runs with the remaining lanes of the enclosing mask. At the join point the unit restores the mask that was active before the branch. A reconvergence stack holds the enclosing masks, so if-else blocks and loops can nest.

Loops use the same masking scheme. Each iteration test removes the lanes whose condition failed. A break command removes lanes from the loop permanently. When no lane is left, the loop test pops the stack and restores the mask from before the loop. A one-cycle skip flag tells the fetch logic that the path just entered has no enabled lane and can be jumped over. A push into a full stack, or a pop or else on an empty stack, is dropped and sets a sticky error flag.

Top module: `simt_mask_unit`

## Requirements
- R1: After reset, active_mask_o is all ones, depth_o is 0, and skip_o and error_o are 0.
- R2: A valid cmd_i=1 (if) with the stack not full pushes the current mask, sets the mask to the old mask AND pred_i, and raises depth_o by one.
- R3: A valid cmd_i=2 (else) with a non-empty stack sets the mask to the top-of-stack mask AND NOT pred_i. The depth does not change.
- R4: A valid cmd_i=3 (endif) with a non-empty stack restores the top-of-stack mask and lowers depth_o by one.
- R5: skip_o is 1 in the cycle after an if, else or break command whose resulting mask is all zeros. It is 0 after a command whose resulting mask is not zero, after an endif or loop-enter, and after any cycle with no valid command.
- R6: A valid cmd_i=4 (loop enter) with the stack not full pushes the current mask, leaves the mask unchanged and raises depth_o by one.
- R7: A valid cmd_i=5 (loop test) sets the mask to the mask AND pred_i. If that result is zero, it instead pops the stack, restores the saved mask and sets skip_o to 1.
- R8: A valid cmd_i=6 (loop break) sets the mask to the mask AND NOT pred_i. The depth does not change.
- R9: An if or loop-enter with depth_o equal to DEPTH changes neither the mask nor the depth, and sets error_o. error_o stays 1 until reset.
- R10: An else, endif or exiting loop test with depth_o equal to 0 leaves the mask and depth unchanged, and sets error_o.
- R11: A cycle with cmd_valid_i low, or with cmd_i=0 or 7, leaves the mask and depth unchanged.
- R12: Nested constructs reconverge in last-in-first-out order. Each endif restores the mask that was active before its matching if.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (0 nop, 1 if, 2 else, 3 endif, 4 loop enter, 5 loop test, 6 loop break) |
| pred_i | input | LANES | Per-lane condition vector |
| active_mask_o | output | LANES | Lanes allowed to commit results |
| skip_o | output | 1 | Path just entered has no active lane |
| depth_o | output | $clog2(DEPTH+1) | Current stack occupancy |
| error_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions check on every cycle the mask algebra of if, else and break commands. They also check that overflow and underflow leave the mask frozen, that the error flag stays set, that idle cycles hold the state, and that the depth stays within bounds. Only the bench's scenarios can show correct restoration from the stack. This covers last-in-first-out reconvergence through nested if-else and loop constructs, the loop exit that pops and restores, and the exact timing of the skip pulse. The bench also runs a complete sweep of every predicate under several enclosing masks.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_IF         = 3'd1,
    CMD_ELSE       = 3'd2,
    CMD_ENDIF      = 3'd3,
    CMD_LOOP_ENTER = 3'd4,
    CMD_LOOP_TEST  = 3'd5,
    CMD_LOOP_BREAK = 3'd6
  } simt_cmd_e;
endpackage

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] din_i,
  output logic [LANES-1:0] top_o,
  output logic [DW-1:0]    depth_o
);
  logic [LANES-1:0] mem_q [DEPTH];
  logic [DW-1:0]    ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (push_i && ptr_q == DW'(g))   mem_q[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_q + 1'b1;
    else if (pop_i)  ptr_q <= ptr_q - 1'b1;
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr_q == DW'(i + 1)) top_o = mem_q[i];
  end

  assign depth_o = ptr_q;
endmodule

// File: rtl/simt_mask_decide.sv
module simt_mask_decide
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] act_i,
  input  logic [LANES-1:0] top_i,
  input  logic [DW-1:0]    depth_i,
  output logic [LANES-1:0] nxt_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             skip_o,
  output logic             err_o
);
  logic full, empty;
  logic [LANES-1:0] test_m;

  assign full   = (depth_i == DW'(DEPTH));
  assign empty  = (depth_i == '0);
  assign test_m = act_i & pred_i;

  always_comb begin
    nxt_o  = act_i;
    push_o = 1'b0;
    pop_o  = 1'b0;
    skip_o = 1'b0;
    err_o  = 1'b0;
    if (cmd_valid_i) begin
      case (cmd_i)
        CMD_IF: begin
          if (full) err_o = 1'b1;
          else begin
            push_o = 1'b1;
            nxt_o  = test_m;
            skip_o = ~|test_m;
          end
        end
        CMD_ELSE: begin
          if (empty) err_o = 1'b1;
          else begin
            nxt_o  = top_i & ~pred_i;
            skip_o = ~|(top_i & ~pred_i);
          end
        end
        CMD_ENDIF: begin
          if (empty) err_o = 1'b1;
          else begin
            pop_o = 1'b1;
            nxt_o = top_i;
          end
        end
        CMD_LOOP_ENTER: begin
          if (full) err_o = 1'b1;
          else      push_o = 1'b1;
        end
        CMD_LOOP_TEST: begin
          if (|test_m) nxt_o = test_m;
          else begin
            // all lanes done: leave loop, jump past it
            skip_o = 1'b1;
            if (empty) err_o = 1'b1;
            else begin
              pop_o = 1'b1;
              nxt_o = top_i;
            end
          end
        end
        CMD_LOOP_BREAK: begin
          nxt_o  = act_i & ~pred_i;
          skip_o = ~|(act_i & ~pred_i);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simt_mask_unit.sv
module simt_mask_unit #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] active_mask_o,
  output logic             skip_o,
  output logic [DW-1:0]    depth_o,
  output logic             error_o
);
  logic [LANES-1:0] act_q, nxt, top;
  logic             skip_q, err_q;
  logic             push, pop, skip_d, err_d;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (act_q),
    .top_o   (top),
    .depth_o (depth_o)
  );

  simt_mask_decide #(.LANES(LANES), .DEPTH(DEPTH)) u_decide (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .pred_i      (pred_i),
    .act_i       (act_q),
    .top_i       (top),
    .depth_i     (depth_o),
    .nxt_o       (nxt),
    .push_o      (push),
    .pop_o       (pop),
    .skip_o      (skip_d),
    .err_o       (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '1;
      skip_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      act_q  <= nxt;
      skip_q <= skip_d;
      err_q  <= err_q | err_d;
    end
  end

  assign active_mask_o = act_q;
  assign skip_o        = skip_q;
  assign error_o       = err_q;
endmodule

// File: rtl/simt_mask_unit_chk.sv
module simt_mask_unit_chk
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_i,
  input logic [LANES-1:0] pred_i,
  input logic [LANES-1:0] active_mask_o,
  input logic             skip_o,
  input logic [DW-1:0]    depth_o,
  input logic             error_o
);
  logic full, empty, idle;
  assign full  = depth_o == DW'(DEPTH);
  assign empty = depth_o == '0;
  assign idle  = !cmd_valid_i || cmd_i == CMD_NOP || cmd_i == 3'd7;

  AST_IF_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == CMD_IF && !full |=>
      active_mask_o == ($past(active_mask_o) & $past(pred_i)) && depth_o == $past(depth_o) + 1'b1); // R2
  AST_ELSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == CMD_ELSE && !empty |=>
      (active_mask_o & $past(pred_i)) == '0 && $stable(depth_o)); // R3
  AST_SKIP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_i == CMD_IF || cmd_i == CMD_ELSE || cmd_i == CMD_LOOP_BREAK) && !error_o |=>
      (error_o || skip_o == (active_mask_o == '0))); // R5
  AST_BREAK_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == CMD_LOOP_BREAK |=>
      active_mask_o == ($past(active_mask_o) & ~$past(pred_i))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_i == CMD_IF || cmd_i == CMD_LOOP_ENTER) && full |=>
      $stable(active_mask_o) && $stable(depth_o) && error_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_i == CMD_ELSE || cmd_i == CMD_ENDIF) && empty |=>
      $stable(active_mask_o) && $stable(depth_o) && error_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(active_mask_o) && $stable(depth_o) && !skip_o); // R11
  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(DEPTH)); // R9
endmodule

bind simt_mask_unit simt_mask_unit_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_simt_mask_unit.sv
module tb_simt_mask_unit;
  localparam int L  = 8;
  localparam int D  = 4;
  localparam int DW = $clog2(D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [L-1:0] pred = '0;
  logic [L-1:0] act;
  logic skip, err;
  logic [DW-1:0] dep;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [L-1:0] m_mask;
  logic [L-1:0] m_stk [D];
  int m_dep;
  logic m_skip, m_err;

  always #5 clk = ~clk;

  simt_mask_unit #(.LANES(L), .DEPTH(D)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_i(cmd), .pred_i(pred),
    .active_mask_o(act), .skip_o(skip), .depth_o(dep), .error_o(err)
  );

  task automatic check(input string tag);
    n_chk++;
    if (act !== m_mask || skip !== m_skip || dep !== DW'(m_dep) || err !== m_err) begin
      n_fail++;
      $display("FAIL %s: act=%h skip=%b dep=%0d err=%b exp act=%h skip=%b dep=%0d err=%b",
               tag, act, skip, dep, err, m_mask, m_skip, m_dep, m_err);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_mask = '1; m_dep = 0; m_skip = 0; m_err = 0;
    check("R1 reset");
  endtask

  // model from the requirements
  task automatic model(input logic v, input logic [2:0] c, input logic [L-1:0] p);
    logic [L-1:0] t;
    m_skip = 0;
    if (!v) return;
    case (c)
      3'd1: if (m_dep == D) m_err = 1;
            else begin m_stk[m_dep] = m_mask; m_dep++; m_mask &= p; m_skip = (m_mask == 0); end
      3'd2: if (m_dep == 0) m_err = 1;
            else begin m_mask = m_stk[m_dep-1] & ~p; m_skip = (m_mask == 0); end
      3'd3: if (m_dep == 0) m_err = 1;
            else begin m_dep--; m_mask = m_stk[m_dep]; end
      3'd4: if (m_dep == D) m_err = 1;
            else begin m_stk[m_dep] = m_mask; m_dep++; end
      3'd5: begin
        t = m_mask & p;
        if (t != 0) m_mask = t;
        else begin
          m_skip = 1;
          if (m_dep == 0) m_err = 1;
          else begin m_dep--; m_mask = m_stk[m_dep]; end
        end
      end
      3'd6: begin m_mask &= ~p; m_skip = (m_mask == 0); end
      default: ;
    endcase
  endtask

  task automatic run(input logic v, input logic [2:0] c, input logic [L-1:0] p, input string tag);
    @(negedge clk); valid = v; cmd = c; pred = p;
    @(negedge clk); valid = 1'b0;
    model(v, c, p);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%h exp completion", act);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 R3 R4 R5: every predicate under several enclosing masks
    foreach (m_stk[i]) m_stk[i] = '0;
    for (int b = 0; b < 3; b++) begin
      logic [L-1:0] base;
      base = (b == 0) ? 8'hFF : (b == 1) ? 8'hA5 : 8'h3C;
      run(1, 3'd1, base, "R2 base");
      for (int p = 0; p < 256; p++) begin
        run(1, 3'd1, L'(p), "R2 R5 if");
        run(1, 3'd2, L'(p), "R3 R5 else");
        run(1, 3'd3, L'(p), "R4 endif");
      end
      run(1, 3'd3, '0, "R4 restore");
    end
    // R12 nesting
    run(1, 3'd1, 8'hF0, "R12 if a");
    run(1, 3'd1, 8'h3C, "R12 if b");
    run(1, 3'd2, 8'h3C, "R12 else b");
    run(1, 3'd3, 8'h00, "R12 endif b");
    run(1, 3'd2, 8'hF0, "R12 else a");
    run(1, 3'd1, 8'h01, "R12 if c");
    run(1, 3'd3, 8'h00, "R12 endif c");
    run(1, 3'd3, 8'h00, "R12 endif a");
    // R6 R7 R8 loops
    run(1, 3'd4, 8'h00, "R6 enter");
    run(1, 3'd5, 8'hF0, "R7 test");
    run(1, 3'd6, 8'h10, "R8 break");
    run(1, 3'd5, 8'h60, "R7 test");
    run(1, 3'd5, 8'h00, "R7 exit");
    run(1, 3'd1, 8'h0F, "R2 if");
    run(1, 3'd4, 8'h00, "R6 enter nested");
    run(1, 3'd5, 8'h03, "R7 test nested");
    run(1, 3'd6, 8'h03, "R8 R5 break all");
    run(1, 3'd5, 8'hFF, "R7 exit nested");
    run(1, 3'd3, 8'h00, "R4 endif");
    // R11 idle
    run(0, 3'd1, 8'h00, "R11 invalid");
    run(1, 3'd7, 8'h00, "R11 code7");
    run(1, 3'd0, 8'h00, "R11 nop");
    // R9 overflow
    for (int i = 0; i < D; i++) run(1, 3'd1, 8'hFF >> i, "R2 fill");
    run(1, 3'd1, 8'h00, "R9 if overflow");
    run(1, 3'd4, 8'h00, "R9 enter overflow");
    for (int i = 0; i < D; i++) run(1, 3'd3, 8'h00, "R4 R12 drain");
    run(1, 3'd0, 8'h00, "R9 sticky");
    // R10 underflow
    do_reset();
    run(1, 3'd3, 8'h00, "R10 endif empty");
    do_reset();
    run(1, 3'd2, 8'h55, "R10 else empty");
    do_reset();
    run(1, 3'd5, 8'h00, "R10 R7 test empty");
    do_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule